// File: doc/BRIEF.md
# Branch Target Buffer

The block is a direct-mapped table that remembers where taken branches went. Every cycle the fetch stage presents its PC; if a valid entry at the PC's index carries a tag equal to the rest of that PC, the block answers in the same cycle with a hit and the stored destination, and fetch jumps there. On a miss, fetch simply continues sequentially.

When a branch resolves, the pipeline reports its PC, whether it was taken, where it actually went, and whether its fetch had hit in the table. From that report the block adds an entry for a taken branch that was not in the table. It keeps an entry whose guess was right. It drops an entry whose guess was wrong. In the cycle after every wrong guess it raises a one-cycle flush together with the PC from which fetch must start again. Direction counters and the pipeline's own squash logic live elsewhere.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, so no fetch PC hits and `flush` is low.
- R2: `fetch_hit` is high in the same cycle exactly when the entry selected by `fetch_pc[IDX_W+1:2]` is valid and its stored tag equals all remaining PC bits (`fetch_pc[PC_W-1:IDX_W+2]` and `fetch_pc[1:0]`). In that case `fetch_target` is the stored destination.
- R3: If a resolve reports a branch that missed and was taken, the block stores that PC with its actual target. In the next cycle it raises `flush` with `restart_pc` equal to the actual target.
- R4: If a resolve reports a branch that missed and was not taken, the table does not change and `flush` stays low.
- R5: If a resolve reports a hit that was taken to the same target the entry holds, there is no flush and the entry stays.
- R6: If a resolve reports a hit that was not taken, the next cycle has `flush` high with `restart_pc` equal to the branch PC plus 4, and the entry is removed.
- R7: If a resolve reports a hit that was taken, but the entry no longer matches or holds a different target, the next cycle has `flush` high with `restart_pc` equal to the actual target. A matching entry is removed.
- R8: A lookup in the same cycle as a resolve update sees the table as it was before that update.
- R9: Two PCs with the same index and different tags share one slot. Inserting the second evicts the first, and the first then misses.
- R10: `flush` is high only in the cycle right after a resolve that mispredicted, and for exactly one cycle per such resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC being fetched |
| fetch_hit | output | 1 | Lookup hit |
| fetch_target | output | PC_W | Predicted next PC on a hit |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | PC_W | Actual taken destination |
| res_was_hit | input | 1 | The branch hit in the table when fetched |
| flush | output | 1 | Kill and restart request |
| restart_pc | output | PC_W | PC at which fetch restarts |

## Verification
The lookup and the resolve update can fall in the same cycle on the same entry. To provoke this, every resolve in the bench drives `fetch_pc` equal to `res_pc`. The bench then compares the lookup taken before the clock edge against a model that has not yet applied the update, and the lookup taken after the edge against the updated model. Sweeps over all 64 slots cover insertion, aliasing, correct hits, not-taken hits, wrong-target hits and stale hits.

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic [PC_W-1:0] fetch_target,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_was_hit,
  output logic            flush,
  output logic [PC_W-1:0] restart_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    dest_q [ENTRIES];

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag;
  assign f_idx = fetch_pc[IDX_W+1:2];
  assign r_idx = res_pc[IDX_W+1:2];
  assign f_tag = {fetch_pc[PC_W-1:IDX_W+2], fetch_pc[1:0]};
  assign r_tag = {res_pc[PC_W-1:IDX_W+2], res_pc[1:0]};

  assign fetch_hit    = valid_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign fetch_target = dest_q[f_idx];

  logic r_match, r_agree, mispredict, do_insert, do_delete;
  assign r_match    = valid_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign r_agree    = r_match && res_taken && (dest_q[r_idx] == res_target);
  assign mispredict = res_was_hit ? !r_agree : res_taken;
  assign do_insert  = res_valid && !res_was_hit && res_taken;
  assign do_delete  = res_valid && res_was_hit && r_match && !r_agree;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (do_insert) valid_q[r_idx] <= 1'b1;
    else if (do_delete) valid_q[r_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (do_insert) begin
      tag_q[r_idx]  <= r_tag;
      dest_q[r_idx] <= res_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush      <= 1'b0;
      restart_pc <= '0;
    end else begin
      flush      <= res_valid && mispredict;
      restart_pc <= res_taken ? res_target : res_pc + PC_W'(4);
    end
  end
endmodule

module btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_hit,
  input logic [PC_W-1:0] fetch_target,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic            res_was_hit,
  input logic            flush,
  input logic [PC_W-1:0] restart_pc
);
  p_flush_after_resolve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(res_valid));

  p_taken_miss_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_was_hit && res_taken) |=> (flush && restart_pc == $past(res_target)));

  p_taken_miss_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_was_hit && res_taken) |=>
      ((fetch_pc != $past(res_pc)) || (fetch_hit && fetch_target == $past(res_target))));

  p_quiet_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_was_hit && !res_taken) |=> !flush);

  p_not_taken_hit_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_was_hit && !res_taken) |=> (flush && restart_pc == $past(res_pc) + PC_W'(4)));

  p_not_taken_hit_removed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_was_hit && !res_taken) |=> ((fetch_pc != $past(res_pc)) || !fetch_hit));
endmodule

bind branch_target_buffer btb_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
  .fetch_target(fetch_target), .res_valid(res_valid), .res_pc(res_pc),
  .res_taken(res_taken), .res_target(res_target), .res_was_hit(res_was_hit),
  .flush(flush), .restart_pc(restart_pc)
);

// File: tb/tb_branch_target_buffer.sv
`timescale 1ns/1ps
module tb_branch_target_buffer;
  localparam int PC_W = 32;
  localparam int N    = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic fetch_hit;
  logic [31:0] fetch_target;
  logic res_valid = 1'b0, res_taken = 1'b0, res_was_hit = 1'b0;
  logic [31:0] res_pc = '0, res_target = '0;
  logic flush;
  logic [31:0] restart_pc;

  branch_target_buffer #(.PC_W(PC_W), .ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
    .fetch_target(fetch_target), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .res_was_hit(res_was_hit),
    .flush(flush), .restart_pc(restart_pc)
  );

  int vectors = 0, errs = 0;
  logic        mv  [N];
  logic [31:0] mpc [N];
  logic [31:0] mtgt[N];

  function automatic int ix(logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic bit mhit(logic [31:0] pc);
    return mv[ix(pc)] && (mpc[ix(pc)] == pc);
  endfunction

  function automatic logic [31:0] mkpc(logic [23:0] tag, int i);
    return {tag, 6'(i), 2'b00};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] pc, string req);
    bit eh;
    fetch_pc = pc;
    #1;
    eh = mhit(pc);
    chk(fetch_hit == eh, {req, " hit"}, 32'(fetch_hit), 32'(eh));
    if (eh) chk(fetch_target == mtgt[ix(pc)], {req, " target"}, fetch_target, mtgt[ix(pc)]);
  endtask

  task automatic resolve(logic [31:0] pc, bit taken, logic [31:0] tgt, bit hit, string req);
    bit match, agree, exp_flush;
    logic [31:0] exp_pc;
    int i;
    @(negedge clk);
    chk(flush == 1'b0, "R10 idle", 32'(flush), 32'd0);
    i = ix(pc);
    res_valid = 1'b1; res_pc = pc; res_taken = taken; res_target = tgt; res_was_hit = hit;
    look(pc, "R8 pre-update lookup");
    match = mhit(pc);
    agree = match && taken && (mtgt[i] == tgt);
    exp_flush = hit ? !agree : taken;
    exp_pc = taken ? tgt : pc + 32'd4;
    @(posedge clk);
    if (!hit && taken) begin mv[i] = 1'b1; mpc[i] = pc; mtgt[i] = tgt; end
    else if (hit && match && !agree) mv[i] = 1'b0;
    @(negedge clk);
    res_valid = 1'b0;
    chk(flush == exp_flush, {req, " flush"}, 32'(flush), 32'(exp_flush));
    if (exp_flush) chk(restart_pc == exp_pc, {req, " restart"}, restart_pc, exp_pc);
    look(pc, "R2 post-update lookup");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 1'b0; mpc[i] = '0; mtgt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(flush == 1'b0, "R1 flush after reset", 32'(flush), 32'd0);
    for (int i = 0; i < N; i++) look(mkpc(24'h00A1B2, i), "R1 empty after reset");

    for (int i = 0; i < N; i++)
      resolve(mkpc(24'h00A1B2, i), 1'b1, 32'h4000_0000 + 32'(i * 16), 1'b0, "R3 taken miss");
    for (int i = 0; i < N; i++) look(mkpc(24'h00A1B2, i), "R2 sweep");
    for (int i = 0; i < N; i++) look(mkpc(24'h00C3D4, i), "R2 tag mismatch");
    look(mkpc(24'h00A1B2, 7) | 32'd2, "R2 low bits in tag");

    for (int i = 0; i < N; i += 2)
      resolve(mkpc(24'h00A1B2, i), 1'b1, 32'h4000_0000 + 32'(i * 16), 1'b1, "R5 correct hit");
    for (int i = 0; i < N; i++)
      resolve(mkpc(24'h0055AA, i), 1'b0, 32'h0, 1'b0, "R4 not-taken miss");
    for (int i = 0; i < N; i++) look(mkpc(24'h00A1B2, i), "R4 table unchanged");

    for (int i = 1; i < N; i += 4)
      resolve(mkpc(24'h00A1B2, i), 1'b0, 32'h0, 1'b1, "R6 not-taken hit");
    for (int i = 3; i < N; i += 4)
      resolve(mkpc(24'h00A1B2, i), 1'b1, 32'h7000_0000 + 32'(i), 1'b1, "R7 wrong target");
    resolve(mkpc(24'h00A1B2, 3), 1'b1, 32'h7100_0000, 1'b1, "R7 stale hit");

    for (int i = 0; i < N; i += 8)
      resolve(mkpc(24'h00BEEF, i), 1'b1, 32'h5000_0000 + 32'(i), 1'b0, "R9 alias insert");
    for (int i = 0; i < N; i += 8) begin
      look(mkpc(24'h00A1B2, i), "R9 evicted");
      look(mkpc(24'h00BEEF, i), "R9 new owner");
    end
    for (int i = 0; i < N; i++) look(mkpc(24'h00A1B2, i), "R2 final sweep");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errs++;
    vectors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule